// File: doc/BRIEF.md
# Data Memory Port Issue Unit with Refusal and Retry

This block sits between a small set of memory request slots and a single downstream cache port. Each cycle, any slot may present an initiate command: a read, a write, or the second half of a split read or write. The block picks one slot, chooses the command to send to the port from the slot's access attributes, and presents it. The port can accept or refuse what it is offered.

A refusal puts the whole port into a blocked state. The prepared request is dropped and the slot is told to present the same request again later. While the port is blocked, no slot can start anything. A retry pulse from the port ends the blocked state. A store-conditional whose verdict is already "fail" never reaches the port: it completes on the spot. An accepted request leaves its slot pending until the port returns a response for it.

Top module: `mem_port_issue`

## Requirements
- R1: A request that is presented on the port but not accepted sets `port_blocked` on the next cycle and raises `slot_again` for that slot, not `slot_done`, in the cycle of the refusal.
- R2: While `port_blocked` is high, `port_valid` stays low, and every requesting non-pending slot gets `slot_again` (op 0 read, 1 write, 2 second-half read, 3 second-half write alike), with no `slot_done`.
- R3: A `port_retry` pulse while blocked clears `port_blocked` on the next cycle. A `port_retry` while not blocked raises `retry_error` in the same cycle.
- R4: An accepted request raises `slot_done` for its slot in the same cycle and sets that slot's `slot_pending` on the next cycle. `port_blocked` is low afterwards.
- R5: A read (op 0 or 2) is sent with `port_cmd` 2 (load-locked) when its load-linked attribute is set, otherwise with 0 (read).
- R6: A write (op 1 or 3) is sent with `port_cmd` 4 (swap) when swap is set, else 3 (store-conditional) when load-linked is set, else 1 (write).
- R7: A write with load-linked set whose store-conditional verdict is fail is not sent to the port. Its slot gets `slot_done` in the same cycle and does not become pending.
- R8: A conditional-swap write raises `port_extra_valid` and carries its slot's comparison operand on `port_extra`. Reads never raise `port_extra_valid`.
- R9: At most one request is presented per cycle. Among requesting, non-pending slots that need the port, the lowest-numbered wins. Losers get `slot_again`. A pending slot is not eligible.
- R10: `port_second` is high exactly when the presented op is a second-half access (op 2 or 3).
- R11: A response with `resp_valid` clears `slot_pending` for `resp_id` on the next cycle.
- R12: After reset, `port_blocked` and all `slot_pending` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_req | input | NSLOT | Slot presents an initiate command |
| slot_op | input | 2*NSLOT | Per slot op: 0 read, 1 write, 2 second-half read, 3 second-half write |
| slot_swap | input | NSLOT | Swap attribute |
| slot_cswap | input | NSLOT | Conditional-swap attribute |
| slot_llsc | input | NSLOT | Load-linked / store-conditional attribute |
| slot_sc_fail | input | NSLOT | Store-conditional verdict is fail |
| slot_cmp | input | DW*NSLOT | Comparison operand per slot |
| port_valid | output | 1 | A request is presented |
| port_cmd | output | 3 | Encoded port command |
| port_second | output | 1 | Presented request is a second-half access |
| port_id | output | $clog2(NSLOT) | Slot number of the presented request |
| port_extra_valid | output | 1 | Comparison operand attached |
| port_extra | output | DW | Comparison operand |
| port_accept | input | 1 | Port takes the presented request |
| port_retry | input | 1 | Port is ready again after a refusal |
| resp_valid | input | 1 | Response for an outstanding access |
| resp_id | input | $clog2(NSLOT) | Slot the response belongs to |
| slot_done | output | NSLOT | Slot completed this cycle |
| slot_again | output | NSLOT | Slot must present its request again |
| slot_pending | output | NSLOT | Slot waits for a port response |
| port_blocked | output | 1 | Port is blocked after a refusal |
| retry_error | output | 1 | Retry arrived while not blocked |

## Verification
The assertions check on every cycle that nothing is presented while blocked, that a refusal leads to the blocked state and a retry leaves it, that an acceptance makes the winning slot pending, and that no slot is both done and told to try again. The command encoding, lowest-slot priority, the local completion of a failed store-conditional and the attached comparison operand depend on the attribute combination, so only the bench's sweeps over every op and attribute combination and over every request pattern can show them.

// File: rtl/mem_port_issue.sv
module mem_port_issue #(
  parameter int NSLOT = 4,
  parameter int DW = 32,
  parameter int SW = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSLOT-1:0]    slot_req,
  input  logic [2*NSLOT-1:0]  slot_op,
  input  logic [NSLOT-1:0]    slot_swap,
  input  logic [NSLOT-1:0]    slot_cswap,
  input  logic [NSLOT-1:0]    slot_llsc,
  input  logic [NSLOT-1:0]    slot_sc_fail,
  input  logic [DW*NSLOT-1:0] slot_cmp,
  output logic                port_valid,
  output logic [2:0]          port_cmd,
  output logic                port_second,
  output logic [SW-1:0]       port_id,
  output logic                port_extra_valid,
  output logic [DW-1:0]       port_extra,
  input  logic                port_accept,
  input  logic                port_retry,
  input  logic                resp_valid,
  input  logic [SW-1:0]       resp_id,
  output logic [NSLOT-1:0]    slot_done,
  output logic [NSLOT-1:0]    slot_again,
  output logic [NSLOT-1:0]    slot_pending,
  output logic                port_blocked,
  output logic                retry_error
);
  localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_LL = 3'd2, C_SC = 3'd3, C_SWP = 3'd4;

  logic [NSLOT-1:0] ready, sc_drop, needs_port, win_oh, clr_oh;
  logic found;
  logic [1:0] w_op;
  logic w_wr;

  assign ready = slot_req & ~slot_pending;

  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      sc_drop[i] = ready[i] & slot_op[2*i] & slot_llsc[i] & slot_sc_fail[i];
  end

  assign needs_port = ready & ~sc_drop;

  always_comb begin
    found = 1'b0;
    win_oh = '0;
    port_id = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (needs_port[i] && !found) begin
        found = 1'b1;
        win_oh[i] = 1'b1;
        port_id = SW'(i);
      end
    end
  end

  assign w_op = slot_op[2*port_id +: 2];
  assign w_wr = w_op[0];

  always_comb begin
    if (!w_wr) port_cmd = slot_llsc[port_id] ? C_LL : C_RD;
    else if (slot_swap[port_id]) port_cmd = C_SWP;
    else if (slot_llsc[port_id]) port_cmd = C_SC;
    else port_cmd = C_WR;
  end

  assign port_valid = found & ~port_blocked;
  assign port_second = port_valid & w_op[1];
  assign port_extra_valid = port_valid & w_wr & slot_cswap[port_id];
  assign port_extra = port_extra_valid ? slot_cmp[DW*port_id +: DW] : '0;

  assign slot_done  = port_blocked ? '0 : (sc_drop | (win_oh & {NSLOT{port_accept}}));
  assign slot_again = port_blocked ? ready : (needs_port & ~(win_oh & {NSLOT{port_accept}}));

  assign retry_error = port_retry & ~port_blocked;

  always_comb begin
    clr_oh = '0;
    if (resp_valid) clr_oh[resp_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_blocked <= 1'b0;
      slot_pending <= '0;
    end else begin
      if (port_valid && !port_accept) port_blocked <= 1'b1;
      else if (port_retry || (port_valid && port_accept)) port_blocked <= 1'b0;
      slot_pending <= (slot_pending | (port_valid && port_accept ? win_oh : '0)) & ~clr_oh;
    end
  end
endmodule

// File: rtl/mem_port_issue_chk.sv
module mem_port_issue_chk #(
  parameter int NSLOT = 4,
  parameter int SW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             port_valid,
  input logic             port_accept,
  input logic             port_retry,
  input logic             port_blocked,
  input logic [SW-1:0]    port_id,
  input logic [NSLOT-1:0] slot_done,
  input logic [NSLOT-1:0] slot_again,
  input logic [NSLOT-1:0] slot_pending
);
  assert_quiet_when_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    port_blocked |-> !port_valid);

  assert_refusal_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && !port_accept) |=> port_blocked);

  assert_retry_unblocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_blocked && port_retry) |=> !port_blocked);

  assert_accept_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && port_accept) |=> (slot_pending[$past(port_id)] && !port_blocked));

  assert_done_again_disjoint_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_done & slot_again) == '0);

  assert_one_done_on_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && port_accept) |-> slot_done[port_id]);
endmodule

bind mem_port_issue mem_port_issue_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_valid(port_valid), .port_accept(port_accept),
  .port_retry(port_retry), .port_blocked(port_blocked), .port_id(port_id),
  .slot_done(slot_done), .slot_again(slot_again), .slot_pending(slot_pending)
);

// File: tb/mem_port_issue_test.sv
`timescale 1ns/1ps
module mem_port_issue_test;
  localparam int N = 4, DW = 8, SW = 2;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = 0, swp = 0, csw = 0, ll = 0, scf = 0;
  logic [2*N-1:0] op = 0;
  logic [DW*N-1:0] cmp = 0;
  logic pv, psec, pxv, acc = 0, rty = 0, rv = 0, blk, rerr;
  logic [2:0] pcmd;
  logic [SW-1:0] pid, rid = 0;
  logic [DW-1:0] px;
  logic [N-1:0] done, again, pend;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mem_port_issue #(.NSLOT(N), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .slot_req(req), .slot_op(op), .slot_swap(swp),
    .slot_cswap(csw), .slot_llsc(ll), .slot_sc_fail(scf), .slot_cmp(cmp),
    .port_valid(pv), .port_cmd(pcmd), .port_second(psec), .port_id(pid),
    .port_extra_valid(pxv), .port_extra(px), .port_accept(acc), .port_retry(rty),
    .resp_valid(rv), .resp_id(rid), .slot_done(done), .slot_again(again),
    .slot_pending(pend), .port_blocked(blk), .retry_error(rerr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    req = 0; swp = 0; csw = 0; ll = 0; scf = 0; op = 0; acc = 0; rty = 0; rv = 0;
  endtask

  task automatic clear_pending();
    for (int s = 0; s < N; s++) begin
      @(negedge clk); idle(); rv = 1; rid = SW'(s);
      @(posedge clk); #1;
    end
    @(negedge clk); rv = 0;
    chk(pend == 0, "R11 pending cleared", int'(pend), 0);
  endtask

  function automatic int exp_cmd(int o, bit s, bit l);
    if (o % 2 == 0) return l ? 2 : 0;
    if (s) return 4;
    return l ? 3 : 1;
  endfunction

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk(blk == 0, "R12 blocked after reset", blk, 0);
    chk(pend == 0, "R12 pending after reset", int'(pend), 0);
    @(negedge clk); rst_n = 1;

    // R5 R6 R8 R10 R4: every op and attribute combination, varied slots
    for (int v = 0; v < 32; v++) begin
      int s, o;
      s = v % N; o = v % 4;
      @(negedge clk); idle();
      req[s] = 1; op[2*s +: 2] = 2'(o);
      swp[s] = v[2]; csw[s] = v[3]; ll[s] = v[4];
      cmp[DW*s +: DW] = DW'(8'h30 + v);
      acc = 1;
      #1;
      chk(pv == 1 && pid == SW'(s), "R9 single slot presented", int'(pid), s);
      chk(pcmd == 3'(exp_cmd(o, v[2], v[4])), o % 2 ? "R6 write command" : "R5 read command",
          pcmd, exp_cmd(o, v[2], v[4]));
      chk(psec == (o >= 2), "R10 second-half flag", psec, o >= 2);
      chk(pxv == ((o % 2 == 1) && v[3]), "R8 operand attached", pxv, (o % 2 == 1) && v[3]);
      if (pxv) chk(px == DW'(8'h30 + v), "R8 operand value", px, 8'h30 + v);
      chk(done == (N'(1) << s) && again == 0, "R4 done on accept", int'(done), 1 << s);
      @(posedge clk); #1;
      chk(pend == (N'(1) << s) && blk == 0, "R4 pending after accept", int'(pend), 1 << s);
      @(negedge clk); idle(); rv = 1; rid = SW'(s);
      @(posedge clk); #1;
      chk(pend == 0, "R11 response clears pending", int'(pend), 0);
    end

    // R9 R1 R2 R3: every request pattern, refused, then held while blocked
    for (int p = 1; p < 16; p++) begin
      int lo;
      lo = 0;
      while (!p[lo]) lo++;
      @(negedge clk); idle();
      req = N'(p); op = 8'b11_10_01_00;
      #1;
      chk(pv && pid == SW'(lo), "R9 lowest slot wins", int'(pid), lo);
      chk(again == N'(p) && done == 0, "R1 refused slot told to retry", int'(again), p);
      @(posedge clk); #1;
      chk(blk == 1, "R1 refusal blocks port", blk, 1);
      @(negedge clk); acc = 1;
      #1;
      chk(pv == 0 && again == N'(p) && done == 0, "R2 nothing issued while blocked", int'(again), p);
      @(posedge clk); #1;
      chk(blk == 1 && pend == 0, "R2 accept ignored while blocked", blk, 1);
      @(negedge clk); idle(); rty = 1;
      #1;
      chk(rerr == 0, "R3 no error on valid retry", rerr, 0);
      @(posedge clk); #1;
      chk(blk == 0, "R3 retry unblocks", blk, 0);
    end

    @(negedge clk); idle(); rty = 1;
    #1;
    chk(rerr == 1, "R3 retry while clear is error", rerr, 1);

    // R7: failed store-conditional completes locally, next slot uses port
    @(negedge clk); idle();
    req = 4'b0110; op[3:2] = 2'd1; ll[1] = 1; scf[1] = 1; op[5:4] = 2'd0; acc = 1;
    #1;
    chk(pv && pid == 2, "R7 failed SC skips port", int'(pid), 2);
    chk(done == 4'b0110 && again == 0, "R7 failed SC completes", int'(done), 6);
    @(posedge clk); #1;
    chk(pend == 4'b0100, "R7 failed SC not pending", int'(pend), 4);

    // R9: pending slot not eligible
    @(negedge clk); idle(); req = 4'b1100; acc = 0;
    #1;
    chk(pv && pid == 3, "R9 pending slot skipped", int'(pid), 3);
    @(posedge clk); #1;
    @(negedge clk); idle(); rty = 1;
    @(posedge clk); #1;
    chk(blk == 0, "R3 unblocked again", blk, 0);
    clear_pending();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule